// File: doc/BRIEF.md
# Low-Speed USB Line Transmitter

This block sends one low-speed USB packet on the differential pair. A start request gives a byte count. The block then sets the lines to the idle J level and turns the drivers on. It sends the sync pattern, then the requested bytes pulled one at a time through a fetch port. It ends with the end-of-packet sequence and turns the drivers off. Every bit goes out least significant bit first, NRZI-coded, with a stuffed toggle after each run of six ones. The block does not add PID or CRC fields: it sends the buffered bytes exactly as stored. A one-byte request gives a handshake reply.

A free-running divider splits the system clock into bit slots of `CLK_DIV` cycles. For a 48 MHz clock the value 32 gives the 1.5 Mbit/s low-speed rate.

The controller has five states:
- `ST_IDLE` holds the levels at J with the drivers off.
- `ST_IDLE` → `ST_LEAD` when a start request is accepted.
- `ST_LEAD` drives J for one slot, then moves to `ST_DATA`.
- `ST_DATA` sends one coded or stuffed bit per slot. When no bits are left and no stuff is due, it moves to `ST_SE0`.
- `ST_SE0` drives both lines low for two slots, then moves to `ST_TAIL`.
- `ST_TAIL` drives J for one slot, then returns to `ST_IDLE`, turns the drivers off and pulses `done_o`.

Top module: `usb_ls_tx`

## Requirements
- R1: After reset, `oe_o`, `done_o` and `fetch_o` are 0 and the lines rest at J (`dp_o`=0, `dm_o`=1).
- R2: When a start is accepted, `oe_o` rises in the same cycle. The first slot is the J state (`dp_o`=0, `dm_o`=1).
- R3: After the lead slot, the block sends the sync byte 0x80 and then bytes 0 to `len_i`-1 of the buffer. Each byte goes out with bit 0 first.
- R4: NRZI coding: a 0 bit swaps the two line levels (J=`dp_o` 0/`dm_o` 1, K=`dp_o` 1/`dm_o` 0), and a 1 bit keeps the present levels.
- R5: After six 1 bits in a row, one extra swap is inserted and the run count starts again from zero. This also happens across byte boundaries and after the last data bit, before end of packet.
- R6: After the last bit, both lines are low for two slots, then J for one slot, then `oe_o` falls.
- R7: `done_o` is high for exactly one cycle: the first cycle in which `oe_o` is low after a packet.
- R8: Every slot, including the lead and end slots, lasts exactly `CLK_DIV` clock cycles, and the line levels change only at slot boundaries.
- R9: `fetch_o` pulses once for each requested byte, with `fetch_idx_o` counting up from 0. `byte_i` is taken in the cycle of the pulse, at least one slot before the byte is sent. With `len_i`=0, only sync is sent and there is no fetch.
- R10: A start request while a packet is in progress has no effect on that packet and does not start another one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, taken only when idle |
| len_i | input | LEN_W | Number of buffer bytes to send after sync |
| fetch_o | output | 1 | Byte fetch strobe |
| fetch_idx_o | output | LEN_W | Buffer index of the requested byte |
| byte_i | input | 8 | Buffer byte, valid in the cycle `fetch_o` is high |
| dp_o | output | 1 | D+ drive level |
| dm_o | output | 1 | D− drive level |
| oe_o | output | 1 | Driver enable |
| done_o | output | 1 | One-cycle pulse when the drivers are released |

## Verification
The bench builds the block with `CLK_DIV`=4 and `LEN_W`=3. A packet of a few bytes then fits in a few hundred cycles. Sampling once per slot captures the whole line waveform, including lead, stuffing and end of packet. The vector table covers these cases:
- a stuffed run that crosses a byte boundary;
- a stuffed bit that falls after the final data bit;
- a run of six ones inside a byte;
- an empty payload.

A directed case sends a second start request in the middle of a packet.

// File: rtl/usb_ls_tx_pkg.sv
package usb_ls_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_DATA,
        ST_SE0,
        ST_TAIL
    } tx_state_e;

    localparam logic [7:0] SYNC_BYTE = 8'h80;
    localparam int         STUFF_RUN = 6;
    localparam int         EOP_SLOTS = 2;

endpackage

// File: rtl/usb_ls_tx_tick.sv
module usb_ls_tx_tick #(
    parameter int DIV = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int             CW   = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0]  LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr || cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = (cnt == LAST) && !clr;

endmodule

// File: rtl/usb_ls_tx_enc.sv
module usb_ls_tx_enc
    import usb_ls_tx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load_idle,
    input  logic step,
    input  logic bit_i,
    output logic line_k,
    output logic stuff_due
);
    localparam int OW = $clog2(STUFF_RUN + 1);

    logic [OW-1:0] ones;
    logic          k_q;

    assign stuff_due = (ones == OW'(STUFF_RUN));
    assign line_k    = k_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            k_q  <= 1'b0;
            ones <= '0;
        end else if (load_idle) begin
            k_q  <= 1'b0;
            ones <= '0;
        end else if (step) begin
            if (stuff_due || !bit_i) begin
                k_q  <= ~k_q;
                ones <= '0;
            end else begin
                ones <= ones + 1'b1;
            end
        end
    end

endmodule

// File: rtl/usb_ls_tx_shift.sv
module usb_ls_tx_shift
    import usb_ls_tx_pkg::*;
#(
    parameter int LEN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic [LEN_W-1:0] len_i,
    input  logic             take,
    input  logic [7:0]       byte_i,
    output logic             bit_o,
    output logic             empty_o,
    output logic             fetch_o,
    output logic [LEN_W-1:0] fetch_idx_o
);
    logic [7:0]       cur;
    logic [7:0]       nxt;
    logic [2:0]       bit_idx;
    logic [LEN_W-1:0] left;
    logic             empty_q;
    logic             fetch_q;
    logic [LEN_W-1:0] idx_q;

    assign bit_o       = cur[0];
    assign empty_o     = empty_q;
    assign fetch_o     = fetch_q;
    assign fetch_idx_o = idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur     <= '0;
            nxt     <= '0;
            bit_idx <= '0;
            left    <= '0;
            empty_q <= 1'b1;
            fetch_q <= 1'b0;
            idx_q   <= '0;
        end else if (init) begin
            cur     <= SYNC_BYTE;
            bit_idx <= '0;
            left    <= len_i;
            empty_q <= 1'b0;
            fetch_q <= (len_i != '0);
            idx_q   <= '0;
        end else begin
            fetch_q <= 1'b0;
            if (fetch_q) begin
                nxt <= byte_i;
            end
            if (take) begin
                if (bit_idx == 3'd7) begin
                    bit_idx <= '0;
                    if (left != '0) begin
                        cur  <= nxt;
                        left <= left - 1'b1;
                        if (left != LEN_W'(1)) begin
                            fetch_q <= 1'b1;
                            idx_q   <= idx_q + 1'b1;
                        end
                    end else begin
                        empty_q <= 1'b1;
                    end
                end else begin
                    cur     <= {1'b0, cur[7:1]};
                    bit_idx <= bit_idx + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/usb_ls_tx.sv
module usb_ls_tx
    import usb_ls_tx_pkg::*;
#(
    parameter int CLK_DIV = 32,
    parameter int LEN_W   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             fetch_o,
    output logic [LEN_W-1:0] fetch_idx_o,
    input  logic [7:0]       byte_i,
    output logic             dp_o,
    output logic             dm_o,
    output logic             oe_o,
    output logic             done_o
);
    localparam int SW = $clog2(EOP_SLOTS);

    tx_state_e     state, state_n;
    logic          accept;
    logic          tick;
    logic          step;
    logic          take;
    logic          line_k;
    logic          stuff_due;
    logic          cur_bit;
    logic          empty;
    logic [SW-1:0] eop_cnt;
    logic          done_q;

    assign accept = (state == ST_IDLE) && start_i;
    assign step   = tick && ((state == ST_LEAD) ||
                    ((state == ST_DATA) && (stuff_due || !empty)));
    assign take   = step && !stuff_due;

    usb_ls_tx_tick #(.DIV(CLK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (accept),
        .tick  (tick)
    );

    usb_ls_tx_enc u_enc (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_idle (accept),
        .step      (step),
        .bit_i     (cur_bit),
        .line_k    (line_k),
        .stuff_due (stuff_due)
    );

    usb_ls_tx_shift #(.LEN_W(LEN_W)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .init        (accept),
        .len_i       (len_i),
        .take        (take),
        .byte_i      (byte_i),
        .bit_o       (cur_bit),
        .empty_o     (empty),
        .fetch_o     (fetch_o),
        .fetch_idx_o (fetch_idx_o)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            eop_cnt <= '0;
            done_q  <= 1'b0;
        end else begin
            state  <= state_n;
            done_q <= (state == ST_TAIL) && tick;
            if (state != ST_SE0) begin
                eop_cnt <= '0;
            end else if (tick) begin
                eop_cnt <= eop_cnt + 1'b1;
            end
        end
    end

    // next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: if (start_i) state_n = ST_LEAD;
            ST_LEAD: if (tick)    state_n = ST_DATA;
            ST_DATA: if (tick && !stuff_due && empty) state_n = ST_SE0;
            ST_SE0:  if (tick && eop_cnt == SW'(EOP_SLOTS - 1)) state_n = ST_TAIL;
            ST_TAIL: if (tick)    state_n = ST_IDLE;
            default:              state_n = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        dp_o = 1'b0;
        dm_o = 1'b1;
        oe_o = 1'b0;
        unique case (state)
            ST_IDLE: begin
                dp_o = 1'b0;
                dm_o = 1'b1;
                oe_o = 1'b0;
            end
            ST_LEAD, ST_DATA: begin
                dp_o = line_k;
                dm_o = ~line_k;
                oe_o = 1'b1;
            end
            ST_SE0: begin
                dp_o = 1'b0;
                dm_o = 1'b0;
                oe_o = 1'b1;
            end
            ST_TAIL: begin
                dp_o = 1'b0;
                dm_o = 1'b1;
                oe_o = 1'b1;
            end
            default: begin
                dp_o = 1'b0;
                dm_o = 1'b1;
                oe_o = 1'b0;
            end
        endcase
    end

    assign done_o = done_q;

endmodule

// File: rtl/usb_ls_tx_chk.sv
module usb_ls_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic dp_o,
    input logic dm_o,
    input logic oe_o,
    input logic done_o,
    input logic fetch_o
);

    AST_LEAD_IS_J: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_o) |-> (!dp_o && dm_o)); // R2

    AST_DONE_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!oe_o && $past(oe_o))); // R7

    AST_RELEASE_GIVES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oe_o) |-> done_o); // R7

    AST_SLOT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_o && !tick) |=> ($stable(dp_o) && $stable(dm_o))); // R8

    AST_FETCH_WHILE_DRIVING: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_o |-> oe_o); // R9

endmodule

bind usb_ls_tx usb_ls_tx_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .dp_o    (dp_o),
    .dm_o    (dm_o),
    .oe_o    (oe_o),
    .done_o  (done_o),
    .fetch_o (fetch_o)
);

// File: tb/sim_usb_ls_tx.sv
module sim_usb_ls_tx;

    localparam int DIV   = 4;
    localparam int LW    = 3;
    localparam int NVEC  = 6;
    localparam int MAXS  = 64;

    // [47:40] expected slots, [39:32] length, [31:0] bytes 0..3 (byte 0 highest)
    localparam logic [47:0] VEC [0:NVEC-1] = '{
        {8'd20, 8'd1, 8'hD2, 8'h00, 8'h00, 8'h00},
        {8'd30, 8'd2, 8'hFF, 8'hFF, 8'h00, 8'h00},
        {8'd12, 8'd0, 8'h00, 8'h00, 8'h00, 8'h00},
        {8'd21, 8'd1, 8'hFC, 8'h00, 8'h00, 8'h00},
        {8'd45, 8'd4, 8'hC3, 8'h3C, 8'h7E, 8'h81},
        {8'd20, 8'd1, 8'h5A, 8'h00, 8'h00, 8'h00}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [LW-1:0] len_i = '0;
    logic          fetch_o;
    logic [LW-1:0] fetch_idx_o;
    logic [7:0]    byte_i;
    logic          dp_o, dm_o, oe_o, done_o;

    logic [7:0] mem [0:7];
    int nchk = 0;
    int nfail = 0;
    int fetch_cnt = 0;
    int fetch_bad = 0;
    int oe_cycles = 0;
    logic exp_dp [0:MAXS-1];
    logic exp_dm [0:MAXS-1];
    logic got_dp [0:MAXS-1];
    logic got_dm [0:MAXS-1];
    int exp_n;
    int got_n;

    always #10 clk = ~clk;

    assign byte_i = mem[fetch_idx_o];

    usb_ls_tx #(.CLK_DIV(DIV), .LEN_W(LW)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
        .fetch_o(fetch_o), .fetch_idx_o(fetch_idx_o), .byte_i(byte_i),
        .dp_o(dp_o), .dm_o(dm_o), .oe_o(oe_o), .done_o(done_o)
    );

    always @(negedge clk) begin
        if (oe_o) oe_cycles++;
        if (fetch_o) begin
            if (int'(fetch_idx_o) != fetch_cnt) fetch_bad++;
            fetch_cnt++;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push(input logic k);
        exp_dp[exp_n] = k;
        exp_dm[exp_n] = ~k;
        exp_n++;
    endtask

    // line model built from R2..R6
    task automatic build_expected(input int len);
        logic k;
        int ones;
        logic [7:0] b;
        k = 1'b0;
        ones = 0;
        exp_n = 0;
        push(k);
        for (int n = 0; n <= len; n++) begin
            b = (n == 0) ? 8'h80 : mem[n-1];
            for (int i = 0; i < 8; i++) begin
                if (ones == 6) begin k = ~k; ones = 0; push(k); end
                if (!b[i]) begin k = ~k; ones = 0; end
                else ones++;
                push(k);
            end
        end
        if (ones == 6) begin k = ~k; push(k); end
        exp_dp[exp_n] = 1'b0; exp_dm[exp_n] = 1'b0; exp_n++;
        exp_dp[exp_n] = 1'b0; exp_dm[exp_n] = 1'b0; exp_n++;
        exp_dp[exp_n] = 1'b0; exp_dm[exp_n] = 1'b1; exp_n++;
    endtask

    task automatic run_packet(input int len, input int slots, input int poke);
        int mism;
        int body_end;
        int eop_bad;
        build_expected(len);
        fetch_cnt = 0;
        fetch_bad = 0;
        @(negedge clk);
        oe_cycles = 0;
        start_i = 1'b1;
        len_i = LW'(len);
        @(negedge clk);
        start_i = 1'b0;
        got_n = 0;
        for (int s = 0; s < MAXS; s++) begin
            if (!oe_o) break;
            got_dp[s] = dp_o;
            got_dm[s] = dm_o;
            got_n++;
            if (s == poke) begin
                start_i = 1'b1;
                len_i = LW'(4);
                @(negedge clk);
                start_i = 1'b0;
                repeat (DIV - 1) @(negedge clk);
            end else begin
                repeat (DIV) @(negedge clk);
            end
        end
        check(done_o == 1'b1, "R7 done at release", int'(done_o), 1);
        check(got_n == exp_n && exp_n == slots, "R5 slot count", got_n, slots);
        check(got_n > 0 && !got_dp[0] && got_dm[0], "R2 lead slot J",
              int'({got_dp[0], got_dm[0]}), 1);
        mism = 0;
        body_end = (got_n < exp_n ? got_n : exp_n) - 3;
        for (int s = 1; s < body_end; s++)
            if (got_dp[s] != exp_dp[s] || got_dm[s] != exp_dm[s]) mism++;
        check(mism == 0, "R3 R4 R5 coded bits mismatches", mism, 0);
        eop_bad = 0;
        if (got_n >= 3) begin
            if (got_dp[got_n-3] || got_dm[got_n-3]) eop_bad++;
            if (got_dp[got_n-2] || got_dm[got_n-2]) eop_bad++;
            if (got_dp[got_n-1] || !got_dm[got_n-1]) eop_bad++;
        end else eop_bad = 3;
        check(eop_bad == 0, "R6 eop shape errors", eop_bad, 0);
        check(oe_cycles == slots * DIV, "R8 driven cycles", oe_cycles, slots * DIV);
        check(fetch_cnt == len && fetch_bad == 0, "R9 fetch count", fetch_cnt, len);
        @(negedge clk);
        check(done_o == 1'b0, "R7 done width", int'(done_o), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(oe_o == 1'b0 && done_o == 1'b0 && fetch_o == 1'b0, "R1 reset outputs",
              int'({oe_o, done_o, fetch_o}), 0);
        check(!dp_o && dm_o, "R1 reset idle level", int'({dp_o, dm_o}), 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int v = 0; v < NVEC; v++) begin
            mem[0] = VEC[v][31:24];
            mem[1] = VEC[v][23:16];
            mem[2] = VEC[v][15:8];
            mem[3] = VEC[v][7:0];
            run_packet(int'(VEC[v][39:32]), int'(VEC[v][47:40]), -1);
            repeat (3) @(negedge clk);
        end

        // R10: second start while a handshake is on the line
        mem[0] = 8'hD2;
        run_packet(1, 20, 5);
        oe_cycles = 0;
        repeat (30 * DIV) @(negedge clk);
        check(oe_cycles == 0, "R10 no restart after busy start", oe_cycles, 0);

        // R9: a fresh start after the ignored one still works
        mem[0] = 8'hFC;
        run_packet(1, 21, -1);

        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule